// File: doc/BRIEF.md
# Branch Target Predictor with Static Backward-Taken Fallback

This block predicts the next fetch address for a front end. It keeps a direct-mapped table of branch records. Each record holds a tag, the last resolved target and a two-bit direction counter. Every cycle the table is read combinationally with the fetch address. On a hit, the stored counter gives the direction, and a taken prediction steers fetch to the stored target.

On a miss, decode may flag the fetched instruction as a branch and supply the target it computed. The block then applies a static rule. A target at or below the branch address counts as a backward branch and is predicted taken. The block raises a one-cycle bubble flag for this case, because decode found the target late. A target above the branch address is predicted not taken and costs nothing. An address that is neither a hit nor a flagged branch falls through to the sequential address.

A resolution port writes the table. A taken branch that missed gets a new record, and its counter starts weakly taken. A branch that hits has its counter stepped and its target refreshed. The output logic picks one of three named paths each cycle:
- PATH_TABLE: a table hit.
- PATH_STATIC: a miss on a flagged branch.
- PATH_SEQ: anything else.

The counter is a four-state machine with these states:
- CTR_STRONG_NT (encoding 0)
- CTR_WEAK_NT (encoding 1)
- CTR_WEAK_T (encoding 2)
- CTR_STRONG_T (encoding 3)

Its transitions are:
- step-up on a taken outcome.
- step-down on a not-taken outcome.
- hold at the saturated ends.

Top module: `btb_predictor`

## Requirements
- R1: After reset every lookup misses (`pred_hit` = 0), whatever the fetch address.
- R2: On a miss with `dec_is_br` = 0, the outputs are: `pred_next_pc` = `fetch_pc` + 4, `pred_taken` = 0, `pred_bubble` = 0.
- R3: On a miss with `dec_is_br` = 1 and `dec_target` <= `fetch_pc`, the outputs are: `pred_taken` = 1, `pred_next_pc` = `dec_target`, `pred_bubble` = 1. A correct prediction on this path costs one cycle.
- R4: On a miss with `dec_is_br` = 1 and `dec_target` > `fetch_pc`, the outputs are: `pred_taken` = 0, `pred_next_pc` = `fetch_pc` + 4, `pred_bubble` = 0. A wrong prediction is charged the misprediction penalty (10 to 15 cycles, 12 in the bench model).
- R5: A resolution with `upd_taken` = 1 for an address that misses creates a record for that address. Later lookups then hit, predict taken (counter CTR_WEAK_T) and return `upd_target`.
- R6: A resolution with `upd_taken` = 0 for an address that misses leaves the table unchanged.
- R7: A resolution that hits moves the counter toward taken on `upd_taken` = 1 and toward not-taken on `upd_taken` = 0, saturating at 3 and 0. The predicted direction is counter bit 1.
- R8: On a hit the decode inputs are ignored and `pred_bubble` = 0. The next PC is the stored target when the counter predicts taken, and `fetch_pc` + 4 when it predicts not taken.
- R9: A resolution that hits replaces the stored target with `upd_target`.
- R10: The table is direct-mapped. The index is PC bits [10:2] and the tag is PC bits [31:11]. Two addresses with the same index and different tags do not both hit, and an allocation evicts the older record.
- R11: A lookup and a resolution to the same index in the same cycle return the contents from before the write. The write is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all valid flags |
| fetch_pc | input | 32 | Address being fetched this cycle |
| dec_is_br | input | 1 | Decode marks the fetched instruction as a branch |
| dec_target | input | 32 | Target computed at decode for the fetched branch |
| upd_valid | input | 1 | Resolution write enable |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target |
| upd_taken | input | 1 | Resolved direction |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Predicted direction |
| pred_hit | output | 1 | The lookup matched a table record |
| pred_bubble | output | 1 | The prediction costs a one-cycle bubble (static taken path) |

## Verification
The embedded properties are checked on every clock. They cover:
- the reset miss.
- the tie between the bubble flag and the static taken path, and the absence of a bubble on hits.
- allocation of a valid record on a taken miss, and no allocation on a not-taken miss.
- holding of a saturated counter.

Only the directed scenarios can show the rest:
- the full counter walk through all four states.
- target refresh.
- eviction by an aliasing address.
- old-contents reads when lookup and write collide.
- the cycle-cost accounting of correct and wrong static predictions.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_state_e;

    typedef enum logic [1:0] {
        PATH_SEQ    = 2'd0,
        PATH_STATIC = 2'd1,
        PATH_TABLE  = 2'd2
    } pred_path_e;
endpackage

// File: rtl/btb_ctr_next.sv
module btb_ctr_next
    import btb_pkg::*;
(
    input  ctr_state_e cur,
    input  logic       taken,
    output ctr_state_e nxt
);
    always_comb begin
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_WEAK_T;
        endcase
    end
endmodule

// File: rtl/btb_static_dir.sv
module btb_static_dir #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] br_pc,
    input  logic [PC_W-1:0] br_target,
    output logic            backward
);
    // target at or below the branch address: loop-closing branch
    assign backward = (br_target <= br_pc);
endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int NUM_ENTRIES = 512,
    parameter int INST_BYTES  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] look_pc,
    output logic            look_hit,
    output ctr_state_e      look_ctr,
    output logic [PC_W-1:0] look_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_taken
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int OFF_W = $clog2(INST_BYTES);
    localparam int TAG_W = PC_W - IDX_W - OFF_W;

    logic [NUM_ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]       tag_q [NUM_ENTRIES];
    logic [PC_W-1:0]        tgt_q [NUM_ENTRIES];
    ctr_state_e             ctr_q [NUM_ENTRIES];

    logic [IDX_W-1:0] l_idx, u_idx;
    logic [TAG_W-1:0] l_tag, u_tag;
    logic             u_hit;
    ctr_state_e       ctr_nx;

    assign l_idx = look_pc[OFF_W +: IDX_W];
    assign l_tag = look_pc[PC_W-1 -: TAG_W];
    assign u_idx = upd_pc[OFF_W +: IDX_W];
    assign u_tag = upd_pc[PC_W-1 -: TAG_W];

    // read before write: lookup sees the array as it stood before this edge
    assign look_hit    = valid_q[l_idx] && (tag_q[l_idx] == l_tag);
    assign look_ctr    = ctr_q[l_idx];
    assign look_target = tgt_q[l_idx];
    assign u_hit       = valid_q[u_idx] && (tag_q[u_idx] == u_tag);

    btb_ctr_next i_ctr_next (
        .cur   (ctr_q[u_idx]),
        .taken (upd_taken),
        .nxt   (ctr_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (upd_valid && (u_hit || upd_taken)) begin
            valid_q[u_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_valid) begin
            if (u_hit) begin
                ctr_q[u_idx] <= ctr_nx;
                tgt_q[u_idx] <= upd_target;
            end else if (upd_taken) begin
                tag_q[u_idx] <= u_tag;
                tgt_q[u_idx] <= upd_target;
                ctr_q[u_idx] <= CTR_WEAK_T;
            end
        end
    end

    p_alloc_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=> valid_q[$past(u_idx)]);

    p_no_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !u_hit)
        |=> (valid_q[$past(u_idx)] == $past(valid_q[u_idx])));

    p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && u_hit && upd_taken && ctr_q[u_idx] == CTR_STRONG_T)
        |=> (ctr_q[$past(u_idx)] == CTR_STRONG_T));

    p_sat_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && u_hit && !upd_taken && ctr_q[u_idx] == CTR_STRONG_NT)
        |=> (ctr_q[$past(u_idx)] == CTR_STRONG_NT));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int NUM_ENTRIES = 512,
    parameter int INST_BYTES  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            dec_is_br,
    input  logic [PC_W-1:0] dec_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_taken,
    output logic [PC_W-1:0] pred_next_pc,
    output logic            pred_taken,
    output logic            pred_hit,
    output logic            pred_bubble
);
    logic            t_hit;
    ctr_state_e      t_ctr;
    logic [PC_W-1:0] t_target;
    logic            backward;
    logic [PC_W-1:0] seq_pc;
    pred_path_e      path;

    assign seq_pc = fetch_pc + PC_W'(INST_BYTES);

    btb_store #(
        .PC_W        (PC_W),
        .NUM_ENTRIES (NUM_ENTRIES),
        .INST_BYTES  (INST_BYTES)
    ) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_pc     (fetch_pc),
        .look_hit    (t_hit),
        .look_ctr    (t_ctr),
        .look_target (t_target),
        .upd_valid   (upd_valid),
        .upd_pc      (upd_pc),
        .upd_target  (upd_target),
        .upd_taken   (upd_taken)
    );

    btb_static_dir #(.PC_W(PC_W)) i_static (
        .br_pc     (fetch_pc),
        .br_target (dec_target),
        .backward  (backward)
    );

    always_comb begin
        if (t_hit)          path = PATH_TABLE;
        else if (dec_is_br) path = PATH_STATIC;
        else                path = PATH_SEQ;
    end

    always_comb begin
        pred_hit     = 1'b0;
        pred_taken   = 1'b0;
        pred_bubble  = 1'b0;
        pred_next_pc = seq_pc;
        unique case (path)
            PATH_TABLE: begin
                pred_hit     = 1'b1;
                pred_taken   = t_ctr[1];
                pred_next_pc = t_ctr[1] ? t_target : seq_pc;
            end
            PATH_STATIC: begin
                pred_taken   = backward;
                pred_bubble  = backward;
                pred_next_pc = backward ? dec_target : seq_pc;
            end
            default: ;
        endcase
    end

    p_reset_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !pred_hit);

    p_bubble_static_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_bubble |-> (!pred_hit && pred_taken && dec_is_br
                         && pred_next_pc == dec_target));

    p_hit_no_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> !pred_bubble);
endmodule

// File: tb/test_btb_predictor.sv
module test_btb_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int MISPRED_PENALTY = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0, dec_target = '0, upd_pc = '0, upd_target = '0;
    logic        dec_is_br = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
    logic [31:0] pred_next_pc;
    logic        pred_taken, pred_hit, pred_bubble;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_predictor i_btb_predictor (
        .clk (clk), .rst_n (rst_n),
        .fetch_pc (fetch_pc), .dec_is_br (dec_is_br), .dec_target (dec_target),
        .upd_valid (upd_valid), .upd_pc (upd_pc), .upd_target (upd_target),
        .upd_taken (upd_taken),
        .pred_next_pc (pred_next_pc), .pred_taken (pred_taken),
        .pred_hit (pred_hit), .pred_bubble (pred_bubble)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic br, input logic [31:0] tgt);
        @(negedge clk);
        fetch_pc = pc; dec_is_br = br; dec_target = tgt;
        #1;
    endtask

    task automatic resolve(input logic [31:0] pc, input logic [31:0] tgt, input logic tk);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_taken = tk;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    function automatic int cost(input logic pt, input logic bub, input logic actual);
        return (pt != actual) ? MISPRED_PENALTY : (bub ? 1 : 0);
    endfunction

    task automatic t_reset;
        look(32'h0000_0300, 1'b0, '0); chk("R1 hit after reset a", pred_hit, 0);
        look(32'hFFFF_FFFC, 1'b1, '0); chk("R1 hit after reset b", pred_hit, 0);
    endtask

    task automatic t_seq;
        look(32'h0000_0100, 1'b0, 32'h0000_0020);
        chk("R2 next", pred_next_pc, 32'h0000_0104);
        chk("R2 taken", pred_taken, 0);
        chk("R2 bubble", pred_bubble, 0);
    endtask

    task automatic t_static;
        look(32'h0000_0200, 1'b1, 32'h0000_0180);
        chk("R3 taken", pred_taken, 1);
        chk("R3 next", pred_next_pc, 32'h0000_0180);
        chk("R3 bubble", pred_bubble, 1);
        chk("R3 cost correct backward", cost(pred_taken, pred_bubble, 1'b1), 1);
        look(32'h0000_0200, 1'b1, 32'h0000_0200);
        chk("R3 equal target taken", pred_taken, 1);
        look(32'h0000_0200, 1'b1, 32'h0000_0280);
        chk("R4 taken", pred_taken, 0);
        chk("R4 next", pred_next_pc, 32'h0000_0204);
        chk("R4 bubble", pred_bubble, 0);
        chk("R4 cost correct forward", cost(pred_taken, pred_bubble, 1'b0), 0);
        chk("R4 cost mispredict", cost(pred_taken, pred_bubble, 1'b1), MISPRED_PENALTY);
    endtask

    task automatic t_nofill_alloc;
        resolve(32'h0000_0300, 32'h0000_0400, 1'b0);
        look(32'h0000_0300, 1'b0, '0);
        chk("R6 no entry on not-taken miss", pred_hit, 0);
        resolve(32'h0000_0300, 32'h0000_0400, 1'b1);
        look(32'h0000_0300, 1'b1, 32'h0000_0500);
        chk("R5 hit", pred_hit, 1);
        chk("R5 taken weak", pred_taken, 1);
        chk("R8 next from table", pred_next_pc, 32'h0000_0400);
        chk("R8 no bubble on hit", pred_bubble, 0);
    endtask

    task automatic t_counter;
        resolve(32'h0000_0300, 32'h0000_0400, 1'b0);          // weak NT
        look(32'h0000_0300, 1'b1, 32'h0000_0100);
        chk("R7 weakNT taken", pred_taken, 0);
        chk("R8 not-taken hit next", pred_next_pc, 32'h0000_0304);
        chk("R8 decode ignored bubble", pred_bubble, 0);
        resolve(32'h0000_0300, 32'h0000_0400, 1'b0);          // strong NT
        resolve(32'h0000_0300, 32'h0000_0400, 1'b0);          // stays strong NT
        resolve(32'h0000_0300, 32'h0000_0400, 1'b1);          // weak NT
        look(32'h0000_0300, 1'b0, '0);
        chk("R7 floor saturation", pred_taken, 0);
        resolve(32'h0000_0300, 32'h0000_0400, 1'b1);          // weak T
        look(32'h0000_0300, 1'b0, '0);
        chk("R7 back to taken", pred_taken, 1);
        for (int i = 0; i < 3; i++) resolve(32'h0000_0300, 32'h0000_0400, 1'b1);
        resolve(32'h0000_0300, 32'h0000_0400, 1'b0);          // weak T
        look(32'h0000_0300, 1'b0, '0);
        chk("R7 ceiling saturation", pred_taken, 1);
        resolve(32'h0000_0300, 32'h0000_0400, 1'b0);          // weak NT
        look(32'h0000_0300, 1'b0, '0);
        chk("R7 step down", pred_taken, 0);
        resolve(32'h0000_0300, 32'h0000_0400, 1'b1);          // weak T
    endtask

    task automatic t_refresh;
        resolve(32'h0000_0300, 32'h0000_0480, 1'b1);          // strong T, new target
        look(32'h0000_0300, 1'b0, '0);
        chk("R9 refreshed target", pred_next_pc, 32'h0000_0480);
    endtask

    task automatic t_alias;
        look(32'h0000_0B00, 1'b0, '0);
        chk("R10 alias misses", pred_hit, 0);
        chk("R10 alias seq next", pred_next_pc, 32'h0000_0B04);
        resolve(32'h0000_0B00, 32'h0000_0040, 1'b1);
        look(32'h0000_0B00, 1'b0, '0);
        chk("R10 alias allocated", pred_next_pc, 32'h0000_0040);
        look(32'h0000_0300, 1'b0, '0);
        chk("R10 older record evicted", pred_hit, 0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        fetch_pc = 32'h0000_0B00; dec_is_br = 1'b0;
        upd_valid = 1'b1; upd_pc = 32'h0000_0B00; upd_target = 32'h0000_0060; upd_taken = 1'b0;
        #1;
        chk("R11 old direction", pred_taken, 1);
        chk("R11 old target", pred_next_pc, 32'h0000_0040);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        chk("R11 write visible next cycle", pred_next_pc, 32'h0000_0B04);
        @(negedge clk);
        fetch_pc = 32'h0000_1000;
        upd_valid = 1'b1; upd_pc = 32'h0000_1000; upd_target = 32'h0000_0010; upd_taken = 1'b1;
        #1;
        chk("R11 miss during allocation", pred_hit, 0);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        chk("R11 hit after allocation", pred_next_pc, 32'h0000_0010);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_seq();
        t_static();
        t_nofill_alloc();
        t_counter();
        t_refresh();
        t_alias();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule